// File: doc/BRIEF.md
# Character LCD Setup and Text Write Controller

This block drives a character display module over an 8-bit parallel bus. The display is only ever written, so its read/write line is held at the write level for good. When reset ends, the controller waits out the display's power-on time. It then sends four fixed setup commands by itself. From that point it takes text bytes from a valid/ready stream and writes each one to the display as character data. A zero byte marks the end of a string and is never sent to the display.

Every transfer uses the same timing. Register-select and the data bus are driven first. Enable then goes high for a fixed time and low for a fixed hold time, and only after that may the next transfer begin. The clear command gets a longer low hold than the other commands. All times are given in microseconds and converted to clock cycles from a clock-frequency parameter in kHz, so a test can use small values and a real system can use the true display delays.

Top module: `lcd_init_writer`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `lcd_en`, `lcd_rs`, `lcd_db` and `in_ready` are all 0. `lcd_rw` is 0 at all times.
- R2: The first rising edge of `lcd_en` comes no sooner than PWRUP_US*CLK_KHZ/1000 cycles after reset is released.
- R3: The first four transfers carry, in this order, 0x38, 0x0E, 0x01 and 0x06, each with `lcd_rs` = 0.
- R4: Every enable pulse stays high for exactly EN_US*CLK_KHZ/1000 cycles, with a minimum of 1.
- R5: After enable falls, it stays low for at least the enable-pulse length before it rises again. After the 0x01 clear command it stays low for at least CLR_US*CLK_KHZ/1000 cycles.
- R6: `lcd_db` and `lcd_rs` hold their value for at least one cycle before enable rises, for the whole high time, and through the cycle in which enable falls.
- R7: `in_ready` is 0 until all four setup commands are done, and 0 whenever a transfer is running, including every cycle in which `lcd_en` is 1. Once setup is done, it is 1 whenever no transfer is running.
- R8: A nonzero byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. It is written with `lcd_rs` = 1. Accepted bytes are written in the order they were accepted, and each is written exactly once.
- R9: A zero byte is accepted under the same handshake but causes no enable pulse. `in_ready` is still 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A text byte is offered |
| in_byte | input | 8 | Text byte; zero ends a string |
| in_ready | output | 1 | The controller can take a byte this cycle |
| lcd_rs | output | 1 | Register select: 0 for a command, 1 for character data |
| lcd_rw | output | 1 | Read/write line, held at 0 (write) |
| lcd_en | output | 1 | Enable strobe |
| lcd_db | output | 8 | Display data bus |

## Verification
Two events can fall in the same cycle. The first is a transfer returning to idle, and the second is a waiting stream byte being accepted. To provoke this, the bench keeps `in_valid` high across all byte values 1 to 255, so each byte is taken on the very first edge at which `in_ready` comes back. The bench then checks that every byte gets exactly one enable pulse, in order, and that the low hold before that pulse was fully kept. Zero terminators are mixed into the same back-to-back stream and also sent after idle gaps. For each one, the bench confirms that no pulse follows and that the final pulse count equals four plus the number of nonzero bytes.

// File: rtl/lcd_pkg.sv
// Package lcd_pkg: shared state types, the fixed setup command list and the
// microsecond-to-cycle conversion used by the display write controller.
package lcd_pkg;

    typedef enum logic [1:0] {X_IDLE, X_SETUP, X_HIGH, X_LOW} xfer_st_t;
    typedef enum logic [1:0] {Q_PWRUP, Q_CMD, Q_CWAIT, Q_STREAM} seq_st_t;

    localparam int unsigned N_SETUP   = 4;
    localparam int unsigned CLEAR_IDX = 2;

    // Setup command by position; the order is the display's required order.
    function automatic logic [7:0] setup_cmd(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h38;  // 8-bit bus, two lines, 5x7 font
            2'd1:    return 8'h0E;  // display on, cursor on, no blink
            2'd2:    return 8'h01;  // clear
            default: return 8'h06;  // increment address, no shift
        endcase
    endfunction

    // Converts a time in microseconds to clock cycles, never less than one.
    function automatic int unsigned us_to_cyc(input int unsigned khz, input int unsigned us);
        int unsigned c;
        c = (khz * us) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/lcd_delay.sv
// Module lcd_delay: down-counter that can be loaded and stops at zero.
// Assumes: INIT fits in W bits. After reset it starts from INIT.
// The expired output reflects the count held in the register.
module lcd_delay #(
    parameter int unsigned W    = 8,
    parameter int unsigned INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load a new count or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= W'(INIT);
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcd_xfer.sv
// Module lcd_xfer: performs one timed bus transfer. It latches the byte and
// register select, spends one setup cycle with enable low, holds enable high
// for EN_CYC cycles, then holds enable low for EN_CYC cycles (CLR_CYC when
// long_in was set) before it reports idle again.
// Assumes: start is raised only while idle is high.
module lcd_xfer #(
    parameter int unsigned W       = 8,
    parameter int unsigned EN_CYC  = 2,
    parameter int unsigned CLR_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       rs_in,
    input  logic       long_in,
    output logic       en,
    output logic       rs,
    output logic [7:0] db,
    output logic       idle
);
    import lcd_pkg::*;

    xfer_st_t     st;
    logic         long_q;
    logic         t_load;
    logic [W-1:0] t_val;
    logic         t_exp;

    // Timer loads at the start of the high phase and again at the start of the low hold.
    always_comb begin
        t_load = (st == X_SETUP) || (st == X_HIGH && t_exp);
        if (st == X_SETUP)  t_val = W'(EN_CYC - 1);
        else if (long_q)    t_val = W'(CLR_CYC - 1);
        else                t_val = W'(EN_CYC - 1);
    end

    lcd_delay #(.W(W), .INIT(0)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .expired(t_exp)
    );

    // Transfer phase sequencing, bus latch and enable generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= X_IDLE;
            en     <= 1'b0;
            rs     <= 1'b0;
            db     <= '0;
            long_q <= 1'b0;
        end else begin
            case (st)
                X_IDLE: if (start) begin
                    db     <= byte_in;
                    rs     <= rs_in;
                    long_q <= long_in;
                    st     <= X_SETUP;
                end
                X_SETUP: begin
                    en <= 1'b1;
                    st <= X_HIGH;
                end
                X_HIGH: if (t_exp) begin
                    en <= 1'b0;
                    st <= X_LOW;
                end
                default: if (t_exp) st <= X_IDLE;
            endcase
        end
    end

    assign idle = (st == X_IDLE);
endmodule

// File: rtl/lcd_init_writer.sv
// Module lcd_init_writer: top of the display write controller. It waits out
// the power-on delay, sends the four setup commands, and then streams
// character bytes from a valid/ready input until a zero terminator, which is
// consumed without a write. All delays come from CLK_KHZ and microsecond values.
// Assumes: the display is never read, so the read/write line is tied to write.
module lcd_init_writer #(
    parameter int unsigned CLK_KHZ  = 50000,
    parameter int unsigned PWRUP_US = 15000,
    parameter int unsigned EN_US    = 1000,
    parameter int unsigned CLR_US   = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_db
);
    import lcd_pkg::*;

    localparam int unsigned PWR_CYC = us_to_cyc(CLK_KHZ, PWRUP_US);
    localparam int unsigned EN_CYC  = us_to_cyc(CLK_KHZ, EN_US);
    localparam int unsigned CLR_RAW = us_to_cyc(CLK_KHZ, CLR_US);
    localparam int unsigned CLR_CYC = (CLR_RAW > EN_CYC) ? CLR_RAW : EN_CYC;
    localparam int unsigned MAXC    = (PWR_CYC > CLR_CYC) ? PWR_CYC : CLR_CYC;
    localparam int unsigned TW      = $clog2(MAXC + 1);

    seq_st_t    st;
    logic [1:0] idx;
    logic       pwr_done;
    logic       x_start;
    logic [7:0] x_byte;
    logic       x_rs;
    logic       x_long;
    logic       x_idle;

    lcd_delay #(.W(TW), .INIT(PWR_CYC - 1)) u_pwr_tmr (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .val('0), .expired(pwr_done)
    );

    // Selects what to send: the current setup command, or an accepted nonzero text byte.
    always_comb begin
        x_start = 1'b0;
        x_byte  = setup_cmd(idx);
        x_rs    = 1'b0;
        x_long  = (idx == 2'(CLEAR_IDX));
        if (st == Q_CMD) begin
            x_start = 1'b1;
        end else if (st == Q_STREAM && in_valid && x_idle && in_byte != 8'h00) begin
            x_start = 1'b1;
            x_byte  = in_byte;
            x_rs    = 1'b1;
            x_long  = 1'b0;
        end
    end

    lcd_xfer #(.W(TW), .EN_CYC(EN_CYC), .CLR_CYC(CLR_CYC)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(x_start), .byte_in(x_byte),
        .rs_in(x_rs), .long_in(x_long), .en(lcd_en), .rs(lcd_rs),
        .db(lcd_db), .idle(x_idle)
    );

    // Moves from power-up, through the setup commands, to streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= Q_PWRUP;
            idx <= '0;
        end else begin
            case (st)
                Q_PWRUP: if (pwr_done) st <= Q_CMD;
                Q_CMD:   st <= Q_CWAIT;
                Q_CWAIT: if (x_idle) begin
                    if (idx == 2'(N_SETUP - 1)) st <= Q_STREAM;
                    else begin
                        idx <= idx + 1'b1;
                        st  <= Q_CMD;
                    end
                end
                default: st <= Q_STREAM;
            endcase
        end
    end

    assign in_ready = (st == Q_STREAM) && x_idle;
    assign lcd_rw   = 1'b0;
endmodule

// File: rtl/lcd_init_writer_chk.sv
// Module lcd_init_writer_chk: property checker bound to lcd_init_writer.
// Assumes: it sees the same ports and parameters as the top module.
module lcd_init_writer_chk #(
    parameter int unsigned CLK_KHZ = 50000,
    parameter int unsigned EN_US   = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       in_ready,
    input logic       lcd_rs,
    input logic       lcd_en,
    input logic [7:0] lcd_db
);
    import lcd_pkg::*;
    localparam int unsigned EN_CYC = us_to_cyc(CLK_KHZ, EN_US);

    int unsigned hi_cnt;

    // Counts the cycles of the current enable-high phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_cnt <= 0;
        else if (lcd_en) hi_cnt <= hi_cnt + 1;
        else             hi_cnt <= 0;
    end

    AST_EN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(lcd_en) |-> hi_cnt == EN_CYC); // R4
    AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6
    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (lcd_en && $past(lcd_en)) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6
    AST_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6
    AST_NOT_READY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) lcd_en |-> !in_ready); // R7
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && in_byte != 8'h00) |=> !in_ready); // R8
    AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && in_byte == 8'h00) |=> in_ready && !lcd_en); // R9
endmodule

bind lcd_init_writer lcd_init_writer_chk #(.CLK_KHZ(CLK_KHZ), .EN_US(EN_US)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_db(lcd_db)
);

// File: tb/tb_lcd_init_writer.sv
// Bench for lcd_init_writer: watches the display bus at the falling clock
// edge and compares it with timing and byte order computed from the requirements.
module tb_lcd_init_writer;
    localparam int unsigned KHZ = 1000, PWR = 20, ENC = 3, CLRC = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, lcd_rs, lcd_rw, lcd_en;
    logic [7:0] lcd_db;

    int checks = 0, fails = 0;
    int pulses = 0, nonzero_sent = 0;
    int since_rst = 0, hi = 0, lo = 0, cycles = 0;
    logic       prev_en = 1'b0, prev_rs = 1'b0, last_clear = 1'b0, stable_hi = 1'b1;
    logic [7:0] prev_db = 8'h00;
    logic [8:0] expq[$];

    lcd_init_writer #(.CLK_KHZ(KHZ), .PWRUP_US(PWR), .EN_US(ENC), .CLR_US(CLRC)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_en(lcd_en), .lcd_db(lcd_db)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
            finish_run();
        end
    end

    // Bus monitor for R2..R7.
    always @(negedge clk) begin
        if (rst_n) begin
            since_rst++;
            if (lcd_en && !prev_en) begin
                chk(lcd_db == prev_db && lcd_rs == prev_rs, "R6 setup", {lcd_rs, lcd_db}, {prev_rs, prev_db});
                chk(!in_ready, "R7 ready in pulse", in_ready, 0);
                if (pulses == 0) chk(since_rst > PWR, "R2 power-up", since_rst, PWR + 1);
                else chk(lo >= (last_clear ? CLRC : ENC), "R5 low hold", lo, last_clear ? CLRC : ENC);
                if (expq.size() == 0) chk(0, "R8 unexpected pulse", {lcd_rs, lcd_db}, 0);
                else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk({lcd_rs, lcd_db} == e, pulses < 4 ? "R3 command" : "R8 data", {lcd_rs, lcd_db}, e);
                end
                last_clear = (lcd_db == 8'h01) && !lcd_rs;
                pulses++;
                hi = 1;
                stable_hi = 1'b1;
            end else if (lcd_en) begin
                hi++;
                if (lcd_db != prev_db || lcd_rs != prev_rs) stable_hi = 1'b0;
            end else if (prev_en) begin
                chk(hi == ENC, "R4 enable width", hi, ENC);
                chk(stable_hi && lcd_db == prev_db && lcd_rs == prev_rs, "R6 hold", {lcd_rs, lcd_db}, {prev_rs, prev_db});
                lo = 1;
            end else lo++;
            prev_en = lcd_en; prev_db = lcd_db; prev_rs = lcd_rs;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        if (b != 8'h00) begin
            expq.push_back({1'b1, b});
            nonzero_sent++;
        end else begin
            @(negedge clk);
            chk(in_ready && !lcd_en, "R9 zero ignored", {in_ready, lcd_en}, 2);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        expq.push_back({1'b0, 8'h38});
        expq.push_back({1'b0, 8'h0E});
        expq.push_back({1'b0, 8'h01});
        expq.push_back({1'b0, 8'h06});
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!lcd_en && !lcd_rs && lcd_db == 8'h00 && !in_ready, "R1 reset state", {in_ready, lcd_en, lcd_rs, lcd_db}, 0);
        chk(lcd_rw == 1'b0, "R1 rw low", lcd_rw, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lcd_en && !in_ready, "R1 after release", {in_ready, lcd_en}, 0);
        repeat (PWR / 2) @(negedge clk);
        chk(!in_ready, "R7 ready during init", in_ready, 0);
        while (!in_ready) @(negedge clk);
        chk(pulses == 4, "R7 ready after setup", pulses, 4);
        // Back-to-back sweep of all nonzero values with zeros mixed in.
        for (int v = 1; v < 256; v++) begin
            send(8'(v));
            if (v % 37 == 0) send(8'h00);
        end
        send(8'h00);
        // Sends separated by idle gaps.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk) in_valid = 1'b0;
            repeat (k * 3) @(negedge clk);
            send(k[0] ? 8'h00 : 8'(8'hA0 + k));
        end
        @(negedge clk) in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        repeat (2 * CLRC) @(negedge clk);
        chk(pulses == 4 + nonzero_sent, "R8 pulse count", pulses, 4 + nonzero_sent);
        chk(expq.size() == 0, "R9 nothing pending", expq.size(), 0);
        chk(in_ready == 1'b1, "R7 ready when idle", in_ready, 1);
        chk(lcd_rw == 1'b0, "R1 rw low at end", lcd_rw, 0);
        finish_run();
    end
endmodule